// File: doc/BRIEF.md
# Register Rename Unit

This block gives each instruction, one per cycle, physical register tags in place of its logical register numbers. Both source operands are looked up in a map table that records, for every logical register, the physical register holding its newest value. An instruction that writes a destination takes a fresh physical register from the head of a first-in first-out pool of unused registers. The map entry for the destination is then pointed at that register. Because each write lands in a different physical register, write-after-read and write-after-write conflicts between instructions disappear. Any later reader of the same logical register is steered to the newest copy.

The destination's earlier physical register is handed back on the allocation port. The commit stage is expected to return it on the release port once the overwriting instruction retires, and released registers join the tail of the pool. When the pool is empty, an instruction that needs a destination is held with a stall and changes nothing. Logical register 0 is a constant: it always maps to physical register 0, and writes to it allocate nothing. The physical register file and any recovery checkpointing sit outside this block.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i, and the pool holds physical registers LOG_REGS up to PHYS_REGS-1, handed out in ascending order.
- R2: `src_a_phys` and `src_b_phys` show the current map entries of `src_a_log` and `src_b_log` in the same cycle, whether or not `in_valid` is high.
- R3: A renaming instruction (`in_valid`=1, `dst_we`=1, `dst_log`≠0, pool not empty) raises `alloc_fire` and receives the pool head on `dst_phys`. From the next cycle on, the map entry of `dst_log` reads as that tag.
- R4: A source naming the same logical register as the instruction's own destination sees the mapping from before this instruction.
- R5: On a renaming instruction, `dst_prev_phys` equals the mapping `dst_log` held before the instruction.
- R6: With `dst_we`=0 or `dst_log`=0, nothing is allocated, the map and pool are unchanged, no stall is raised, and `dst_phys`/`dst_prev_phys` read 0.
- R7: If the pool is empty when an instruction needs a destination, `stall`=1, `alloc_fire`=0, both destination outputs read 0, and the map and pool are left unchanged.
- R8: A tag on `rel_phys` with `rel_valid`=1 joins the tail of the pool. Tags then leave the pool in the order they entered.
- R9: A release and an allocation in the same cycle are both carried out and the pool count stays balanced. A release into an empty pool does not lift that cycle's stall, but its tag serves the next allocation.
- R10: With `in_valid`=0 there is no stall and no allocation, and the map and pool do not change apart from any release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| src_a_log | input | $clog2(LOG_REGS) | First logical source register |
| src_b_log | input | $clog2(LOG_REGS) | Second logical source register |
| dst_log | input | $clog2(LOG_REGS) | Logical destination register |
| dst_we | input | 1 | Instruction writes its destination |
| rel_valid | input | 1 | A physical register is returned this cycle |
| rel_phys | input | $clog2(PHYS_REGS) | Returned physical register tag |
| src_a_phys | output | $clog2(PHYS_REGS) | Physical tag of the first source |
| src_b_phys | output | $clog2(PHYS_REGS) | Physical tag of the second source |
| dst_phys | output | $clog2(PHYS_REGS) | Newly allocated destination tag, 0 when none |
| dst_prev_phys | output | $clog2(PHYS_REGS) | Prior mapping of the destination, 0 when none |
| alloc_fire | output | 1 | A destination was allocated this cycle |
| stall | output | 1 | Instruction held because the pool is empty |

## Verification
Two pairs of functions can land in the same cycle. A release can coincide with an allocation, and a source lookup can coincide with the remapping of the same logical register. The release case is driven both with registers left in the pool and with the pool drained. The result is judged from what follows: the order of later allocations, and the cycle in which the stall appears or clears. Same-register cases are swept over every logical destination, and the source tag must match the reported prior mapping rather than the new tag. A long pseudo-random run that mixes all of these is compared against an arithmetic model of the map and the pool, kept in the bench.

// File: rtl/rename_pkg.sv
// Package rename_pkg
// Default sizes and a width helper shared by the rename unit's modules.
// Assumes nothing beyond elaboration-time integer arithmetic.
package rename_pkg;
    localparam int unsigned RN_LOG_REGS_DFLT  = 8;
    localparam int unsigned RN_PHYS_REGS_DFLT = 16;

    // Bits needed to index n items, never less than one.
    function automatic int unsigned rn_idx_w(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rename_free_list.sv
// Module rename_free_list
// Circular FIFO of unused physical register tags. Pop takes the head and
// push appends at the tail; both may happen in one cycle.
// Assumes: the caller never pops when empty and never pushes into a full
// pool. After reset the pool holds LOG_REGS .. PHYS_REGS-1 in ascending order.
module rename_free_list
    import rename_pkg::*;
#(
    parameter int unsigned LOG_REGS  = RN_LOG_REGS_DFLT,
    parameter int unsigned PHYS_REGS = RN_PHYS_REGS_DFLT
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               pop,
    input  logic                               push,
    input  logic [rn_idx_w(PHYS_REGS)-1:0]     push_tag,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     head_tag,
    output logic                               empty
);
    localparam int unsigned DEPTH = PHYS_REGS;
    localparam int unsigned TW    = rn_idx_w(PHYS_REGS);
    localparam int unsigned PW    = rn_idx_w(DEPTH);
    localparam int unsigned CW    = $clog2(DEPTH + 1);
    localparam int unsigned INIT  = PHYS_REGS - LOG_REGS;

    logic [DEPTH-1:0][TW-1:0] slots;
    logic [PW-1:0]            rd_ptr;
    logic [PW-1:0]            wr_ptr;
    logic [CW-1:0]            count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // Head of the pool and its empty flag.
    always_comb begin
        head_tag = slots[rd_ptr];
        empty    = (count == '0);
    end

    // Pool storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                slots[i] <= (i < int'(INIT)) ? TW'(int'(LOG_REGS) + i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= PW'(INIT);
            count  <= CW'(INIT);
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_tag;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + CW'(1);
            end else if (pop && !push) begin
                count <= count - CW'(1);
            end
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count != CW'(DEPTH)));

    p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

    p_count_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count == $past(count) + CW'(1)));

    p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count == $past(count) - CW'(1)));

    p_count_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(count));
endmodule

// File: rtl/rename_map_table.sv
// Module rename_map_table
// Logical-to-physical map with two read ports for sources and one read
// port for the destination's prior mapping. All reads see the table before
// this cycle's write.
// Assumes: entry 0 is never rewritten; writes to index 0 are dropped.
module rename_map_table
    import rename_pkg::*;
#(
    parameter int unsigned LOG_REGS  = RN_LOG_REGS_DFLT,
    parameter int unsigned PHYS_REGS = RN_PHYS_REGS_DFLT
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [rn_idx_w(LOG_REGS)-1:0]      rd_a_idx,
    input  logic [rn_idx_w(LOG_REGS)-1:0]      rd_b_idx,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     rd_a_tag,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     rd_b_tag,
    input  logic                               wr_en,
    input  logic [rn_idx_w(LOG_REGS)-1:0]      wr_idx,
    input  logic [rn_idx_w(PHYS_REGS)-1:0]     wr_tag,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     old_tag
);
    localparam int unsigned TW = rn_idx_w(PHYS_REGS);

    logic [LOG_REGS-1:0][TW-1:0] map_q;

    // Lookups from the registered table.
    always_comb begin
        rd_a_tag = map_q[rd_a_idx];
        rd_b_tag = map_q[rd_b_idx];
        old_tag  = map_q[wr_idx];
    end

    // Identity mapping at reset, then one remap per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(LOG_REGS); i++) begin
                map_q[i] <= TW'(i);
            end
        end else if (wr_en && (wr_idx != '0)) begin
            map_q[wr_idx] <= wr_tag;
        end
    end

    p_zero_pinned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (map_q[0] == '0));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(map_q));
endmodule

// File: rtl/rename_unit.sv
// Module rename_unit
// Renames one instruction per cycle: source lookup, destination allocation
// from the free pool, map update, and return of released tags to the pool.
// Assumes: each released tag is a prior mapping that was handed out on
// dst_prev_phys and has not been released before.
module rename_unit
    import rename_pkg::*;
#(
    parameter int unsigned LOG_REGS  = RN_LOG_REGS_DFLT,
    parameter int unsigned PHYS_REGS = RN_PHYS_REGS_DFLT
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic [rn_idx_w(LOG_REGS)-1:0]      src_a_log,
    input  logic [rn_idx_w(LOG_REGS)-1:0]      src_b_log,
    input  logic [rn_idx_w(LOG_REGS)-1:0]      dst_log,
    input  logic                               dst_we,
    input  logic                               rel_valid,
    input  logic [rn_idx_w(PHYS_REGS)-1:0]     rel_phys,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     src_a_phys,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     src_b_phys,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     dst_phys,
    output logic [rn_idx_w(PHYS_REGS)-1:0]     dst_prev_phys,
    output logic                               alloc_fire,
    output logic                               stall
);
    localparam int unsigned TW = rn_idx_w(PHYS_REGS);

    logic          needs_dst;
    logic          pool_empty;
    logic [TW-1:0] pool_head;
    logic [TW-1:0] prior_tag;

    // Decide whether this instruction allocates or is held.
    always_comb begin
        needs_dst     = in_valid && dst_we && (dst_log != '0);
        stall         = needs_dst && pool_empty;
        alloc_fire    = needs_dst && !pool_empty;
        dst_phys      = alloc_fire ? pool_head : '0;
        dst_prev_phys = alloc_fire ? prior_tag : '0;
    end

    rename_map_table #(
        .LOG_REGS (LOG_REGS),
        .PHYS_REGS(PHYS_REGS)
    ) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_a_idx(src_a_log),
        .rd_b_idx(src_b_log),
        .rd_a_tag(src_a_phys),
        .rd_b_tag(src_b_phys),
        .wr_en   (alloc_fire),
        .wr_idx  (dst_log),
        .wr_tag  (pool_head),
        .old_tag (prior_tag)
    );

    rename_free_list #(
        .LOG_REGS (LOG_REGS),
        .PHYS_REGS(PHYS_REGS)
    ) u_pool (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (alloc_fire),
        .push    (rel_valid),
        .push_tag(rel_phys),
        .head_tag(pool_head),
        .empty   (pool_empty)
    );

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!stall && !alloc_fire));

    p_fresh_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |-> (dst_phys != dst_prev_phys));

    p_src_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && (src_a_log == dst_log)) |-> (src_a_phys == dst_prev_phys));

    p_redirect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !rel_valid) ##1 (src_b_log == $past(dst_log))
            |-> (src_b_phys == $past(dst_phys)));

    p_stall_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !rel_valid) |=> (stall || !in_valid || !dst_we
                                   || (dst_log == '0) || !$stable(dst_log)
                                   || !$stable(in_valid)) || stall);
endmodule

// File: tb/tb_rename_unit.sv
// Bench for rename_unit: directed corner sequences followed by a long
// pseudo-random run, all compared against an arithmetic model of the map
// and the pool.
module tb_rename_unit;
    localparam int LOGR   = 8;
    localparam int PHYSR  = 16;
    localparam int LW     = $clog2(LOGR);
    localparam int TW     = $clog2(PHYSR);
    localparam int PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [LW-1:0] src_a_log = '0;
    logic [LW-1:0] src_b_log = '0;
    logic [LW-1:0] dst_log = '0;
    logic          dst_we = 1'b0;
    logic          rel_valid = 1'b0;
    logic [TW-1:0] rel_phys = '0;
    logic [TW-1:0] src_a_phys, src_b_phys, dst_phys, dst_prev_phys;
    logic          alloc_fire, stall;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    int mmap [0:LOGR-1];
    int fq   [0:63];
    int fhead, ftail, fcnt;
    int pend [0:63];
    int phead, ptail, pcnt;

    always #(PERIOD/2) clk = ~clk;

    rename_unit #(.LOG_REGS(LOGR), .PHYS_REGS(PHYSR)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a_log(src_a_log), .src_b_log(src_b_log), .dst_log(dst_log),
        .dst_we(dst_we), .rel_valid(rel_valid), .rel_phys(rel_phys),
        .src_a_phys(src_a_phys), .src_b_phys(src_b_phys), .dst_phys(dst_phys),
        .dst_prev_phys(dst_prev_phys), .alloc_fire(alloc_fire), .stall(stall)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < LOGR; i++) mmap[i] = i;
        for (int i = 0; i < PHYSR - LOGR; i++) fq[i] = LOGR + i;
        fhead = 0; ftail = PHYSR - LOGR; fcnt = PHYSR - LOGR;
        phead = 0; ptail = 0; pcnt = 0;
    endtask

    // One instruction: drive after a falling edge, compare, advance model.
    task automatic step(input bit v, input int sa, input int sb, input int d,
                        input bit we, input bit rv, input string tag);
        int  rp;
        bit  rel;
        bit  need, fire;
        int  e_dst, e_prev;
        rel = rv && (pcnt > 0);
        rp  = rel ? pend[phead] : 0;
        in_valid  = v;
        src_a_log = LW'(sa);
        src_b_log = LW'(sb);
        dst_log   = LW'(d);
        dst_we    = we;
        rel_valid = rel;
        rel_phys  = TW'(rp);
        #1;
        need   = v && we && (d != 0);
        fire   = need && (fcnt > 0);
        e_dst  = fire ? fq[fhead] : 0;
        e_prev = fire ? mmap[d] : 0;
        check(tag, "src_a_phys", int'(src_a_phys), mmap[sa]);
        check(tag, "src_b_phys", int'(src_b_phys), mmap[sb]);
        check(tag, "stall", int'(stall), int'(need && !fire));
        check(tag, "alloc_fire", int'(alloc_fire), int'(fire));
        check(tag, "dst_phys", int'(dst_phys), e_dst);
        check(tag, "dst_prev_phys", int'(dst_prev_phys), e_prev);
        if (fire) begin
            pend[ptail] = e_prev; ptail = (ptail + 1) % 64; pcnt++;
            mmap[d] = e_dst;
            fhead = (fhead + 1) % 64; fcnt--;
        end
        if (rel) begin
            phead = (phead + 1) % 64; pcnt--;
            fq[ftail] = rp; ftail = (ftail + 1) % 64; fcnt++;
        end
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit [31:0] lcg;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map after reset, every pair of lookups
        for (int a = 0; a < LOGR; a++)
            for (int b = 0; b < LOGR; b++)
                step(1'b0, a, b, a, 1'b1, 1'b0, "R1/R2/R10");

        // R1, R3, R4, R5: ascending allocation, source equals destination
        for (int d = 1; d < LOGR; d++)
            step(1'b1, d, d - 1, d, 1'b1, 1'b0, "R1/R3/R4/R5");
        step(1'b1, 2, 1, 1, 1'b1, 1'b0, "R3/R4");
        // R3: later reader sees newest tag
        step(1'b0, 1, 7, 0, 1'b0, 1'b0, "R3");

        // R7: pool empty now
        step(1'b1, 3, 1, 3, 1'b1, 1'b0, "R7");
        step(1'b1, 3, 1, 3, 1'b1, 1'b0, "R7");
        // R6: register 0 and no-write instructions
        step(1'b1, 0, 3, 0, 1'b1, 1'b0, "R6");
        step(1'b1, 5, 5, 5, 1'b0, 1'b0, "R6");
        // R10: invalid slot
        step(1'b0, 5, 4, 5, 1'b1, 1'b0, "R10");

        // R9: release into empty pool does not lift this cycle's stall
        step(1'b1, 5, 5, 5, 1'b1, 1'b1, "R9");
        step(1'b1, 5, 6, 6, 1'b1, 1'b0, "R9/R8");
        step(1'b1, 6, 6, 6, 1'b1, 1'b0, "R7");

        // R8: several releases then allocations in the same order
        for (int k = 0; k < 3; k++) step(1'b0, k, k + 1, 2, 1'b1, 1'b1, "R8/R10");
        for (int k = 0; k < 3; k++) step(1'b1, k + 2, 7, k + 2, 1'b1, 1'b0, "R8");

        // R9: release and allocation together with entries in the pool
        step(1'b0, 0, 0, 0, 1'b0, 1'b1, "R8");
        step(1'b1, 4, 4, 4, 1'b1, 1'b1, "R9");
        step(1'b1, 4, 4, 7, 1'b1, 1'b0, "R9");
        step(1'b1, 7, 4, 1, 1'b1, 1'b0, "R9/R7");

        // R2/R9: pseudo-random mix against the model
        lcg = 32'h1234_5678;
        for (int n = 0; n < 3000; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            step(lcg[16] | lcg[17], int'(lcg[20:18]), int'(lcg[23:21]),
                 int'(lcg[26:24]), lcg[27] | lcg[28], lcg[29] | lcg[30],
                 "R2/R3/R9");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule